// File: doc/BRIEF.md
# Resolver and Synchro Signal Synthesizer

This block turns a 12-bit shaft angle and a stream of signed samples of an AC excitation waveform into the stator signals that a resolver or a three-wire synchro would produce at that shaft position. It is meant for test stands, shaft-position simulators and drive loops that need emulated sensor feedback. A host presents the angle with a strobe pulse. The block works out the trigonometric coefficients for that angle and then multiplies every new excitation sample by them.

Two output formats come from the same angle path. In resolver format two channels carry the excitation scaled by the cosine and by the sine of the angle. In synchro format three channels carry the negated excitation scaled by the sine of the angle and of the angle advanced by one third and by two thirds of a turn. A configuration input inverts the top angle bit before lookup, which corrects the inverted phasing of the synchro signals.

The sines are produced one after another by one shared rotation engine. They are collected in a shadow bank and all take effect together when the conversion finishes. While the engine is working, a busy flag is high and the output-valid flag is held low.

Top module: `resolver_synchro_gen`

## Requirements
- R1: The angle is captured on the rising edge of `angle_stb_i`, that is, in a cycle where the strobe is high and was low one cycle earlier. A conversion starts on the falling edge of the strobe. `synchro_sel_i` and `msb_flip_i` are sampled at that falling edge. Both strobe edges are ignored while `busy_o` is high.
- R2: In resolver format (`synchro_sel_i`=0) the outputs are: `out_a_o` = ref·cos(2π·φ/4096), `out_b_o` = ref·sin(2π·φ/4096), and `out_c_o` = 0.
- R3: In synchro format (`synchro_sel_i`=1) the three outputs are −ref·sin of the angle codes φ, (φ+1365) mod 4096 and (φ+2731) mod 4096, on `out_a_o`, `out_b_o` and `out_c_o` respectively.
- R4: In synchro format with `msb_flip_i`=1, φ is replaced by φ XOR 0x800 (bit 11 inverted) before the offsets are added. In resolver format `msb_flip_i` has no effect.
- R5: `busy_o` rises in the cycle after the falling strobe edge is detected. It stays high for exactly 16 cycles in resolver format and 48 cycles in synchro format. All coefficients change together at the edge where `busy_o` falls.
- R6: `out_vld_o` is high for one cycle after a clock edge at which `ref_vld_i` was high, `busy_o` was low, `angle_stb_i` was low, and at least one conversion had finished since reset. Outputs update one cycle after every sample.
- R7: Each output is rounded to nearest and saturated to the signed range −32768..32767.
- R8: Every valid output lies within 12 LSB of the ideal value clipped to that range.
- R9: After reset `busy_o` and `out_vld_o` are low and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| angle_i | input | 12 | Shaft angle code, full turn = 4096 |
| angle_stb_i | input | 1 | Angle strobe: rise captures, fall starts |
| synchro_sel_i | input | 1 | 0 selects resolver format, 1 selects synchro format |
| msb_flip_i | input | 1 | Inverts angle bit 11 in synchro format |
| ref_i | input | 16 | Signed excitation sample |
| ref_vld_i | input | 1 | Excitation sample present |
| busy_o | output | 1 | Conversion in progress |
| out_vld_o | output | 1 | Outputs hold a valid product |
| out_a_o | output | 16 | Channel A (cosine, or first synchro phase) |
| out_b_o | output | 16 | Channel B (sine, or second synchro phase) |
| out_c_o | output | 16 | Channel C (zero, or third synchro phase) |

## Verification
A wrong sequencer state shows up first on `busy_o`: its length moves away from 16 or 48 cycles, and that is visible at the first conversion. A corrupted coefficient shows up as an output error on the very next valid sample after `busy_o` falls. Errors in offset, negation, MSB inversion or rounding show up as a value off by far more than the tolerance. A missing clip shows up as a sign flip when a full-scale sample meets a unit coefficient. A gating fault shows up as `out_vld_o` being high during busy or strobe cycles, at the first sample sent in such a window.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  localparam int CORDIC_STEPS = 14;
  localparam int NCH = 3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_ROT, SQ_STORE} seq_state_e;

  // Arctangent of 2^-k, with one full turn = 65536 units.
  function automatic int atan_unit(input int k);
    case (k)
      0:  return 8192;
      1:  return 4836;
      2:  return 2555;
      3:  return 1297;
      4:  return 651;
      5:  return 326;
      6:  return 163;
      7:  return 81;
      8:  return 41;
      9:  return 20;
      10: return 10;
      11: return 5;
      12: return 3;
      13: return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rsg_strobe_ctl.sv
module rsg_strobe_ctl #(
  parameter int ANG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic [ANG_W-1:0] angle_i,
  input  logic             busy_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             start_o,
  output logic [ANG_W-1:0] angle_o
);
  logic stb_q;
  logic [ANG_W-1:0] lat_q;

  assign rise_o  = stb_i & ~stb_q;
  assign fall_o  = ~stb_i & stb_q;
  assign start_o = fall_o & ~busy_i;
  assign angle_o = lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      lat_q <= '0;
    end else begin
      stb_q <= stb_i;
      if (rise_o && !busy_i) lat_q <= angle_i;
    end
  end
endmodule

// File: rtl/rsg_sequencer.sv
module rsg_sequencer #(
  parameter int ANG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             syn_i,
  input  logic             flip_i,
  input  logic [ANG_W-1:0] angle_i,
  output logic             busy_o,
  output logic             load_o,
  output logic             step_o,
  output logic [3:0]       step_idx_o,
  output logic             store_o,
  output logic             commit_o,
  output logic [1:0]       ch_o,
  output logic             syn_o,
  output logic [ANG_W-1:0] ang_o
);
  import rsg_pkg::*;

  localparam logic [ANG_W-1:0] MSB_MASK = ANG_W'(1) << (ANG_W - 1);
  localparam logic [ANG_W-1:0] OFF1 = ANG_W'(((2 ** ANG_W) + 1) / 3);
  localparam logic [ANG_W-1:0] OFF2 = ANG_W'(((2 ** (ANG_W + 1)) + 1) / 3);
  localparam logic [3:0] LAST_STEP = 4'(CORDIC_STEPS - 1);

  seq_state_e state_q;
  logic [1:0] ch_q;
  logic [3:0] step_q;
  logic syn_q;
  logic [ANG_W-1:0] base_q;
  logic last_ch;
  logic [ANG_W-1:0] offset;

  assign last_ch    = syn_q ? (ch_q == 2'd2) : (ch_q == 2'd0);
  assign busy_o     = (state_q != SQ_IDLE);
  assign load_o     = (state_q == SQ_LOAD);
  assign step_o     = (state_q == SQ_ROT);
  assign store_o    = (state_q == SQ_STORE);
  assign commit_o   = store_o & last_ch;
  assign step_idx_o = step_q;
  assign ch_o       = ch_q;
  assign syn_o      = syn_q;

  always_comb begin
    case (ch_q)
      2'd1:    offset = OFF1;
      2'd2:    offset = OFF2;
      default: offset = '0;
    endcase
    ang_o = base_q + (syn_q ? offset : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ch_q    <= '0;
      step_q  <= '0;
      syn_q   <= 1'b0;
      base_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start_i) begin
          state_q <= SQ_LOAD;
          ch_q    <= '0;
          syn_q   <= syn_i;
          base_q  <= angle_i ^ ((syn_i && flip_i) ? MSB_MASK : '0);
        end
        SQ_LOAD: begin
          state_q <= SQ_ROT;
          step_q  <= '0;
        end
        SQ_ROT: begin
          step_q <= step_q + 4'd1;
          if (step_q == LAST_STEP) state_q <= SQ_STORE;
        end
        default: begin
          if (last_ch) state_q <= SQ_IDLE;
          else begin
            ch_q    <= ch_q + 2'd1;
            state_q <= SQ_LOAD;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rsg_cordic.sv
module rsg_cordic #(
  parameter int ANG_W  = 12,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [ANG_W-1:0]         angle_i,
  input  logic                     step_i,
  input  logic [3:0]               step_idx_i,
  output logic signed [COEF_W-1:0] cos_o,
  output logic signed [COEF_W-1:0] sin_o
);
  localparam int GUARD = 4;
  localparam int IFRAC = COEF_W - 2 + GUARD;
  localparam int XW    = COEF_W + GUARD + 2;
  localparam int ZW    = 18;
  localparam int PH_SH = 16 - ANG_W;
  localparam logic signed [XW-1:0] X_INIT = XW'(39797) <<< (IFRAC - 16);
  localparam logic signed [XW-1:0] RND    = XW'(1) <<< (GUARD - 1);

  logic signed [XW-1:0] x_q, y_q, xs, ys, xr, yr;
  logic signed [ZW-1:0] z_q, at;
  logic neg_q, fold;
  logic [15:0] ph16;
  logic signed [COEF_W-1:0] cw, sw;

  always_comb begin
    fold = angle_i[ANG_W-1] ^ angle_i[ANG_W-2];
    ph16 = 16'(angle_i) << PH_SH;
    if (fold) ph16[15] = ~ph16[15];
    xs = x_q >>> step_idx_i;
    ys = y_q >>> step_idx_i;
    at = ZW'(rsg_pkg::atan_unit(int'(step_idx_i)));
    xr = (x_q + RND) >>> GUARD;
    yr = (y_q + RND) >>> GUARD;
    cw = COEF_W'(xr);
    sw = COEF_W'(yr);
    cos_o = neg_q ? -cw : cw;
    sin_o = neg_q ? -sw : sw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      neg_q <= 1'b0;
    end else if (load_i) begin
      x_q   <= X_INIT;
      y_q   <= '0;
      z_q   <= ZW'(signed'(ph16));
      neg_q <= fold;
    end else if (step_i) begin
      if (!z_q[ZW-1]) begin
        x_q <= x_q - ys;
        y_q <= y_q + xs;
        z_q <= z_q - at;
      end else begin
        x_q <= x_q + ys;
        y_q <= y_q - xs;
        z_q <= z_q + at;
      end
    end
  end
endmodule

// File: rtl/rsg_coef_bank.sv
module rsg_coef_bank #(
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     store_i,
  input  logic                     commit_i,
  input  logic                     syn_i,
  input  logic [1:0]               ch_i,
  input  logic signed [COEF_W-1:0] cos_i,
  input  logic signed [COEF_W-1:0] sin_i,
  output logic signed [COEF_W-1:0] coef_o [rsg_pkg::NCH],
  output logic                     act_syn_o,
  output logic                     have_o
);
  import rsg_pkg::*;

  logic signed [COEF_W-1:0] shd_q [NCH];
  logic signed [COEF_W-1:0] shd_d [NCH];
  logic signed [COEF_W-1:0] act_q [NCH];

  always_comb begin
    for (int k = 0; k < NCH; k++) shd_d[k] = shd_q[k];
    if (store_i) begin
      if (syn_i) begin
        for (int k = 0; k < NCH; k++)
          if (ch_i == 2'(k)) shd_d[k] = -sin_i;
      end else begin
        shd_d[0] = cos_i;
        shd_d[1] = sin_i;
        shd_d[2] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) begin
        shd_q[k] <= '0;
        act_q[k] <= '0;
      end
      act_syn_o <= 1'b0;
      have_o    <= 1'b0;
    end else begin
      for (int k = 0; k < NCH; k++) shd_q[k] <= shd_d[k];
      if (commit_i) begin
        for (int k = 0; k < NCH; k++) act_q[k] <= shd_d[k];
        act_syn_o <= syn_i;
        have_o    <= 1'b1;
      end
    end
  end

  always_comb for (int k = 0; k < NCH; k++) coef_o[k] = act_q[k];
endmodule

// File: rtl/rsg_out_chan.sv
module rsg_out_chan #(
  parameter int REF_W  = 16,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_i,
  input  logic signed [REF_W-1:0]  ref_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [OUT_W-1:0]  out_o
);
  localparam int PW = REF_W + COEF_W;
  localparam int CF = COEF_W - 2;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (CF - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [PW-1:0] ref_x, coef_x, prod, rnd;
  logic signed [OUT_W-1:0] sat;

  always_comb begin
    ref_x  = ref_i;
    coef_x = coef_i;
    prod   = ref_x * coef_x;
    rnd    = (prod + HALF) >>> CF;
    if (rnd > MAXV)      sat = OUT_W'(MAXV);
    else if (rnd < MINV) sat = OUT_W'(MINV);
    else                 sat = OUT_W'(rnd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     out_o <= '0;
    else if (vld_i) out_o <= sat;
  end
endmodule

// File: rtl/resolver_synchro_gen.sv
module resolver_synchro_gen #(
  parameter int ANG_W  = 12,
  parameter int REF_W  = 16,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ANG_W-1:0]        angle_i,
  input  logic                    angle_stb_i,
  input  logic                    synchro_sel_i,
  input  logic                    msb_flip_i,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic                    ref_vld_i,
  output logic                    busy_o,
  output logic                    out_vld_o,
  output logic signed [OUT_W-1:0] out_a_o,
  output logic signed [OUT_W-1:0] out_b_o,
  output logic signed [OUT_W-1:0] out_c_o
);
  import rsg_pkg::*;

  logic stb_rise, stb_fall, start_evt, commit_evt;
  logic conv_busy, conv_syn, act_syn, have_coef;
  logic ld, stp, sto;
  logic [3:0] stp_idx;
  logic [1:0] ch;
  logic [ANG_W-1:0] lat_angle, eng_angle;
  logic signed [COEF_W-1:0] cos_w, sin_w;
  logic signed [COEF_W-1:0] coef [NCH];
  logic signed [OUT_W-1:0] chan_out [NCH];
  logic vld_q;

  rsg_strobe_ctl #(.ANG_W(ANG_W)) u_stb (
    .clk(clk), .rst_n(rst_n), .stb_i(angle_stb_i), .angle_i(angle_i),
    .busy_i(conv_busy), .rise_o(stb_rise), .fall_o(stb_fall),
    .start_o(start_evt), .angle_o(lat_angle)
  );

  rsg_sequencer #(.ANG_W(ANG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_evt), .syn_i(synchro_sel_i),
    .flip_i(msb_flip_i), .angle_i(lat_angle), .busy_o(conv_busy),
    .load_o(ld), .step_o(stp), .step_idx_o(stp_idx), .store_o(sto),
    .commit_o(commit_evt), .ch_o(ch), .syn_o(conv_syn), .ang_o(eng_angle)
  );

  rsg_cordic #(.ANG_W(ANG_W), .COEF_W(COEF_W)) u_rot (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .angle_i(eng_angle),
    .step_i(stp), .step_idx_i(stp_idx), .cos_o(cos_w), .sin_o(sin_w)
  );

  rsg_coef_bank #(.COEF_W(COEF_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .store_i(sto), .commit_i(commit_evt),
    .syn_i(conv_syn), .ch_i(ch), .cos_i(cos_w), .sin_i(sin_w),
    .coef_o(coef), .act_syn_o(act_syn), .have_o(have_coef)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    rsg_out_chan #(.REF_W(REF_W), .COEF_W(COEF_W), .OUT_W(OUT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .vld_i(ref_vld_i), .ref_i(ref_i),
      .coef_i(coef[g]), .out_o(chan_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= ref_vld_i & ~conv_busy & ~angle_stb_i & have_coef;
  end

  assign busy_o    = conv_busy;
  assign out_vld_o = vld_q;
  assign out_a_o   = chan_out[0];
  assign out_b_o   = chan_out[1];
  assign out_c_o   = chan_out[2];
endmodule

// File: rtl/resolver_synchro_gen_chk.sv
module resolver_synchro_gen_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             out_vld_o,
  input logic [OUT_W-1:0] out_c_o,
  input logic             angle_stb_i,
  input logic             ref_vld_i,
  input logic             start_evt,
  input logic             commit_evt,
  input logic             conv_syn,
  input logic             act_syn
);
  import rsg_pkg::*;
  localparam int PER_CH = CORDIC_STEPS + 2;

  int busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)      busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy_o);

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (busy_cnt == (conv_syn ? 3 * PER_CH - 1 : PER_CH - 1)));

  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(commit_evt));

  assert_vld_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_o |-> $past(ref_vld_i && !busy_o && !angle_stb_i));

  assert_res_c_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_o && !act_syn) |-> (out_c_o == '0));
endmodule

bind resolver_synchro_gen resolver_synchro_gen_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .out_vld_o(out_vld_o),
  .out_c_o(out_c_o), .angle_stb_i(angle_stb_i), .ref_vld_i(ref_vld_i),
  .start_evt(start_evt), .commit_evt(commit_evt), .conv_syn(conv_syn),
  .act_syn(act_syn)
);

// File: tb/resolver_synchro_gen_test.sv
module resolver_synchro_gen_test;
  localparam real PI  = 3.14159265358979;
  localparam int  TOL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] angle_i = '0;
  logic angle_stb_i = 1'b0, synchro_sel_i = 1'b0, msb_flip_i = 1'b0, ref_vld_i = 1'b0;
  logic signed [15:0] ref_i = '0;
  logic busy_o, out_vld_o;
  logic signed [15:0] out_a_o, out_b_o, out_c_o;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  resolver_synchro_gen uut (
    .clk(clk), .rst_n(rst_n), .angle_i(angle_i), .angle_stb_i(angle_stb_i),
    .synchro_sel_i(synchro_sel_i), .msb_flip_i(msb_flip_i), .ref_i(ref_i),
    .ref_vld_i(ref_vld_i), .busy_o(busy_o), .out_vld_o(out_vld_o),
    .out_a_o(out_a_o), .out_b_o(out_b_o), .out_c_o(out_c_o)
  );

  always #2 clk = ~clk;

  // Behavioural model state
  int m_stb_q = 0, m_busy = 0, m_lat = 0;
  bit m_have = 0, m_vld = 0, m_act_syn = 0, m_p_syn = 0;
  real m_c [3], m_p [3], m_exp [3];

  function automatic real clip(input real v);
    if (v > 32767.0) return 32767.0;
    if (v < -32768.0) return -32768.0;
    return v;
  endfunction

  function automatic real sinq(input int a);
    return $sin(2.0 * PI * real'(a % 4096) / 4096.0);
  endfunction

  function automatic real cosq(input int a);
    return $cos(2.0 * PI * real'(a % 4096) / 4096.0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stb_q = 0; m_busy = 0; m_lat = 0; m_have = 0; m_vld = 0; m_act_syn = 0;
      for (int k = 0; k < 3; k++) begin m_c[k] = 0.0; m_exp[k] = 0.0; end
    end else begin
      m_vld = ref_vld_i && (m_busy == 0) && !angle_stb_i && m_have;
      if (ref_vld_i) for (int k = 0; k < 3; k++) m_exp[k] = real'(ref_i) * m_c[k];
      if (m_busy != 0) begin
        m_busy--;
        if (m_busy == 0) begin
          for (int k = 0; k < 3; k++) m_c[k] = m_p[k];
          m_have = 1; m_act_syn = m_p_syn;
        end
      end else begin
        if (angle_stb_i && m_stb_q == 0) m_lat = int'(angle_i);
        if (!angle_stb_i && m_stb_q == 1) begin
          int eff;
          m_p_syn = synchro_sel_i;
          eff = (synchro_sel_i && msb_flip_i) ? (m_lat ^ 2048) : m_lat;  // R4
          if (synchro_sel_i) begin  // R3
            m_p[0] = -sinq(eff); m_p[1] = -sinq(eff + 1365); m_p[2] = -sinq(eff + 2731);
            m_busy = 48;
          end else begin            // R2
            m_p[0] = cosq(eff); m_p[1] = sinq(eff); m_p[2] = 0.0;
            m_busy = 16;
          end
        end
      end
      m_stb_q = angle_stb_i ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  task automatic chk_val(input int act, input real ideal);
    real e;
    string tag;
    e = clip(ideal);
    tag = (ideal > 32767.0 || ideal < -32768.0) ? "R7" : (m_act_syn ? "R3/R8" : "R2/R8");
    chk((real'(act) - e <= real'(TOL)) && (e - real'(act) <= real'(TOL)), tag, act, int'(e));
  endtask

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy_o == (m_busy != 0), "R5 busy", int'(busy_o), int'(m_busy != 0));
      chk(out_vld_o == m_vld, "R6 valid", int'(out_vld_o), int'(m_vld));
      if (m_vld) begin
        chk_val(int'(out_a_o), m_exp[0]);
        chk_val(int'(out_b_o), m_exp[1]);
        chk_val(int'(out_c_o), m_exp[2]);
      end
    end
  end

  task automatic strobe(input int ang, input bit syn, input bit flip, input int hold);
    @(negedge clk);
    angle_i = 12'(ang); synchro_sel_i = syn; msb_flip_i = flip; angle_stb_i = 1'b1;
    repeat (hold) @(negedge clk);
    angle_stb_i = 1'b0;
  endtask

  task automatic stream();
    int vals [8] = '{32767, -32768, 20000, -12345, 0, 1, -1, 16384};
    foreach (vals[i]) begin
      @(negedge clk); ref_i = 16'(vals[i]); ref_vld_i = 1'b1;
    end
    @(negedge clk); ref_vld_i = 1'b0;
  endtask

  task automatic convert(input int ang, input bit syn, input bit flip);
    strobe(ang, syn, flip, 1);
    repeat (52) @(negedge clk);
    stream();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busy_o == 1'b0, "R9", int'(busy_o), 0);
    chk(out_vld_o == 1'b0, "R9", int'(out_vld_o), 0);
    chk(out_a_o == 0 && out_b_o == 0 && out_c_o == 0, "R9", int'(out_a_o), 0);
    rst_n = 1'b1;
    // R6: samples before any conversion give no valid output
    stream();
    // R2 resolver at several angles, including unit coefficients (R7 clip)
    convert(0, 0, 0);
    convert(512, 0, 0);
    convert(1024, 0, 0);
    convert(2048, 0, 0);
    convert(3000, 0, 0);
    convert(4095, 0, 0);
    // R4: flip has no effect in resolver format
    convert(700, 0, 1);
    // R3 synchro, with and without flip (R4)
    convert(1024, 1, 0);
    convert(700, 1, 0);
    convert(700, 1, 1);
    convert(3500, 1, 1);
    convert(0, 1, 0);
    // R1/R6: samples and a second strobe during busy are ignored
    strobe(300, 1, 0, 1);
    repeat (4) @(negedge clk);
    fork
      stream();
      strobe(2222, 0, 1, 2);
    join
    repeat (50) @(negedge clk);
    stream();
    // R6: long strobe with samples while high, then conversion
    fork
      strobe(1500, 0, 0, 10);
      stream();
    join
    repeat (52) @(negedge clk);
    stream();
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule